// File: doc/BRIEF.md
# Tagged Receive Queue with Edge Interrupt

This block is the shared receive queue of a multi-channel serial controller. Three kinds of entry come in through a single write port: received characters, modem-status change reports and diagnostic codes. A character carries its channel number and its error flags. Software reads the queue through one read port. Each 16-bit word it reads carries a data-valid bit, so a driver can keep reading until it sees that bit clear.

The queue drives a data-available level and two occupancy levels, half full and three-quarters full, for the flow-control logic. It also drives a receive interrupt request that is edge based. A request is raised when data becomes available while the enable is set, or when the enable is set while data is already available. A driver that leaves entries behind must clear the enable and set it again to get another request.

A write that arrives while the queue is full is dropped. The channel is remembered, and the next character stored for that channel is marked with the overrun flag. The depth is a parameter, and both occupancy thresholds are derived from it.

Top module: `rx_tag_queue`

## Requirements
- R1: A character word has bit 15 = 1 (valid), bit 14 = overrun, bit 13 = framing, bit 12 = parity, bits 11:8 = channel and bits 7:0 = the character. wr_kind 0 selects a character, and wr_err[2:0] gives {overrun, framing, parity}.
- R2: A modem-status write (wr_kind 1) is stored with bits 14:12 = 111, bit 0 = 0 and bits 7:1 = wr_data[6:0].
- R3: A diagnostic write (wr_kind 2 or 3) is stored with bits 14:12 = 111, bit 0 = 1 and bits 7:1 = wr_data[6:0].
- R4: The error field 111 is reserved for special entries. A character whose final flags would be 111 is stored with parity cleared, as 110.
- R5: rd_entry shows the oldest entry, and entries come out in write order. With the queue empty, rd_entry is 16'h0000 and a read removes nothing.
- R6: data_avail is 1 exactly when at least one entry is held.
- R7: half_full is 1 when the count is at least DEPTH/2. three_q_full is 1 when the count is at least 3*DEPTH/4.
- R8: A write while the queue holds DEPTH entries, with no read in the same cycle, is dropped. The stored contents do not change.
- R9: After a dropped write on a channel, the next character stored for that channel has the overrun bit set. Characters on other channels are not affected.
- R10: rx_irq pulses high for one cycle when data_avail rises while irq_en is 1. It does not pulse again while data_avail stays 1.
- R11: rx_irq pulses when irq_en rises while data_avail is 1.
- R12: After reset the queue is empty, and data_avail, half_full, three_q_full and rx_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 character, 1 modem status, 2/3 diagnostic |
| wr_chan | input | 4 | Channel number |
| wr_err | input | 3 | {overrun, framing, parity} for characters |
| wr_data | input | 8 | Character, or 7-bit info in [6:0] |
| rd_en | input | 1 | Remove the shown entry |
| rd_entry | output | 16 | Oldest entry, or zero when empty |
| irq_en | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| data_avail | output | 1 | Queue not empty |
| half_full | output | 1 | Count at least DEPTH/2 |
| three_q_full | output | 1 | Count at least 3*DEPTH/4 |

## Verification
The hardest case to reach is the pending overrun. It needs a full queue, then a dropped write on one channel, then a drain, and only then can the next characters show whether the mark landed on the right channel. The bench uses a depth of 8 and fills the queue while checking both occupancy levels at every count. It then drops a write for one channel, drains the queue in order and writes to a different channel before the marked one. The interrupt re-arm case is reached by leaving entries in the queue and dropping the enable for one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic [1:0] {
      KIND_CHAR  = 2'd0,
      KIND_MODEM = 2'd1,
      KIND_DIAG  = 2'd2,
      KIND_DIAG2 = 2'd3
   } rxq_kind_e;

   typedef struct packed {
      logic       valid;
      logic [2:0] err;
      logic [3:0] chan;
      logic [7:0] body;
   } rxq_word_t;

   localparam logic [2:0] ERR_SPECIAL = 3'b111;
endpackage

// File: rtl/rxq_pack.sv
module rxq_pack
   import rxq_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_kind,
   input  logic [3:0] wr_chan,
   input  logic [2:0] wr_err,
   input  logic [7:0] wr_data,
   input  logic       full,
   output rxq_word_t  word
);
   logic [NCH-1:0] pend_q;
   logic           pend_hit;
   logic [2:0]     err_raw;

   always_comb begin
      pend_hit = 1'b0;
      for (int i = 0; i < NCH; i++)
         if (wr_chan == 4'(i)) pend_hit = pend_q[i];
   end

   always_comb begin
      err_raw    = {wr_err[2] | pend_hit, wr_err[1:0]};
      word.valid = 1'b1;
      word.chan  = wr_chan;
      unique case (rxq_kind_e'(wr_kind))
         KIND_CHAR: begin
            word.err  = (err_raw == ERR_SPECIAL) ? 3'b110 : err_raw;
            word.body = wr_data;
         end
         KIND_MODEM: begin
            word.err  = ERR_SPECIAL;
            word.body = {wr_data[6:0], 1'b0};
         end
         default: begin
            word.err  = ERR_SPECIAL;
            word.body = {wr_data[6:0], 1'b1};
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else if (wr_en) begin
         for (int i = 0; i < NCH; i++) begin
            if (wr_chan == 4'(i)) begin
               if (full) pend_q[i] <= 1'b1;
               else if (wr_kind == KIND_CHAR) pend_q[i] <= 1'b0;
            end
         end
      end
   end

   // R4: a character never takes the reserved error pattern
   assert_char_not_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == KIND_CHAR) |-> (word.err != ERR_SPECIAL));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  rxq_word_t     wr_word,
   input  logic          rd_en,
   output logic [15:0]   rd_entry,
   output logic [CW-1:0] count,
   output logic          full
);
   rxq_word_t     mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic          do_wr, do_rd, empty;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp_q <= wp_nx;
         if (do_rd) rp_q <= rp_nx;
         if (do_wr && !do_rd)      count <= count + 1'b1;
         else if (do_rd && !do_wr) count <= count - 1'b1;
      end
   end

   assign rd_entry = empty ? 16'h0000 : mem[rp_q];

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> (count == CW'(DEPTH)));
   assert_empty_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (rd_entry[15] == 1'b0));
endmodule

// File: rtl/rxq_notify.sv
module rxq_notify #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int HALF_T = DEPTH / 2,
   localparam int TQ_T = (3 * DEPTH) / 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic          irq_en,
   output logic          data_avail,
   output logic          half_full,
   output logic          three_q_full,
   output logic          rx_irq
);
   logic cond, cond_q;

   assign data_avail   = (count != '0);
   assign half_full    = (count >= CW'(HALF_T));
   assign three_q_full = (count >= CW'(TQ_T));
   assign cond         = irq_en && data_avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign rx_irq = cond && !cond_q;

   assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && irq_en && data_avail) |=> !rx_irq || !$past(irq_en) || !irq_en);
   assert_irq_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (irq_en && data_avail));
   assert_level_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      three_q_full |-> half_full);
endmodule

// File: rtl/rx_tag_queue.sv
module rx_tag_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int NCH   = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_kind,
   input  logic [3:0]  wr_chan,
   input  logic [2:0]  wr_err,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   output logic [15:0] rd_entry,
   input  logic        irq_en,
   output logic        rx_irq,
   output logic        data_avail,
   output logic        half_full,
   output logic        three_q_full
);
   initial begin
      assert (DEPTH >= 4) else $error("DEPTH must be at least 4");
      assert (NCH >= 1 && NCH <= 16) else $error("NCH must be 1..16");
   end

   rxq_word_t     word;
   logic          full;
   logic [CW-1:0] count;

   rxq_pack #(.NCH(NCH)) u_pack (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_chan(wr_chan), .wr_err(wr_err), .wr_data(wr_data),
      .full(full), .word(word));

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(word),
      .rd_en(rd_en), .rd_entry(rd_entry), .count(count), .full(full));

   rxq_notify #(.DEPTH(DEPTH)) u_notify (
      .clk(clk), .rst_n(rst_n), .count(count), .irq_en(irq_en),
      .data_avail(data_avail), .half_full(half_full),
      .three_q_full(three_q_full), .rx_irq(rx_irq));

   assert_avail_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_avail == rd_entry[15]);
endmodule

// File: tb/tb_rx_tag_queue.sv
module tb_rx_tag_queue;
   localparam int DEPTH = 8;
   localparam int NCH   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, irq_en = 1'b0;
   logic [1:0]  wr_kind = '0;
   logic [3:0]  wr_chan = '0;
   logic [2:0]  wr_err = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] rd_entry;
   logic        rx_irq, data_avail, half_full, three_q_full;
   int          checks = 0, errors = 0;

   always #5 clk = ~clk;

   rx_tag_queue #(.DEPTH(DEPTH), .NCH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_chan(wr_chan), .wr_err(wr_err), .wr_data(wr_data),
      .rd_en(rd_en), .rd_entry(rd_entry), .irq_en(irq_en),
      .rx_irq(rx_irq), .data_avail(data_avail), .half_full(half_full),
      .three_q_full(three_q_full));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] k, input logic [3:0] ch,
                     input logic [2:0] e, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_chan = ch; wr_err = e; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(output logic [15:0] v);
      @(negedge clk);
      v = rd_entry;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  d;
      logic [2:0]  e;
      repeat (3) @(negedge clk);
      chk("R12 entry", rd_entry, 16'h0000);
      chk("R12 flags", {12'h0, data_avail, half_full, three_q_full, rx_irq}, 16'h0);
      rst_n = 1'b1;

      // R1 and R4: every channel and every error pattern
      for (int ch = 0; ch < NCH; ch++) begin
         for (int ev = 0; ev < 8; ev++) begin
            d = 8'((ch * 37 + ev * 11 + 5) % 256);
            wr(2'd0, 4'(ch), 3'(ev), d);
            chk("R6 avail after write", {15'h0, data_avail}, 16'h1);
            rd(v);
            e = (ev == 7) ? 3'b110 : 3'(ev);
            chk(ev == 7 ? "R4 reserved flags" : "R1 char layout", v,
                {1'b1, e, 4'(ch), d});
         end
      end
      // R2 / R3: special entries
      wr(2'd1, 4'd2, 3'b000, 8'h55);
      rd(v);
      chk("R2 modem", v, {1'b1, 3'b111, 4'd2, 7'h55, 1'b0});
      wr(2'd2, 4'd1, 3'b000, 8'h83);
      rd(v);
      chk("R3 diag", v, {1'b1, 3'b111, 4'd1, 7'h03, 1'b1});
      wr(2'd3, 4'd3, 3'b010, 8'h7F);
      rd(v);
      chk("R3 diag kind 3", v, {1'b1, 3'b111, 4'd3, 7'h7F, 1'b1});
      rd(v);
      chk("R5 empty read", v, 16'h0000);
      chk("R6 empty avail", {15'h0, data_avail}, 16'h0);

      // R7 fill sweep, irq disabled
      for (int k = 1; k <= DEPTH; k++) begin
         wr(2'd0, 4'd1, 3'b000, 8'(k));
         chk("R7 half", {15'h0, half_full}, {15'h0, k >= DEPTH / 2});
         chk("R7 threeq", {15'h0, three_q_full}, {15'h0, k >= (3 * DEPTH) / 4});
         chk("R10 no irq when disabled", {15'h0, rx_irq}, 16'h0);
      end
      // R8 drop on channel 2
      wr(2'd0, 4'd2, 3'b000, 8'hEE);
      chk("R8 still full", {15'h0, three_q_full}, 16'h1);
      for (int k = 1; k <= DEPTH; k++) begin
         rd(v);
         chk("R5/R8 order", v, {1'b1, 3'b000, 4'd1, 8'(k)});
         chk("R7 half drain", {15'h0, half_full}, {15'h0, (DEPTH - k) >= DEPTH / 2});
      end
      rd(v);
      chk("R8 dropped entry absent", v, 16'h0000);

      // R9 pending overrun only on channel 2; a modem entry keeps it pending
      wr(2'd0, 4'd3, 3'b000, 8'h11);
      wr(2'd1, 4'd2, 3'b000, 8'h01);
      wr(2'd0, 4'd2, 3'b001, 8'h22);
      wr(2'd0, 4'd2, 3'b000, 8'h33);
      rd(v); chk("R9 other channel clean", v, {1'b1, 3'b000, 4'd3, 8'h11});
      rd(v); chk("R9 special untouched", v, {1'b1, 3'b111, 4'd2, 8'h02});
      rd(v); chk("R9 overrun marked", v, {1'b1, 3'b101, 4'd2, 8'h22});
      rd(v); chk("R9 cleared after use", v, {1'b1, 3'b000, 4'd2, 8'h33});

      // R10 / R11 interrupt
      @(negedge clk); irq_en = 1'b1;
      @(negedge clk);
      chk("R10 no irq when empty", {15'h0, rx_irq}, 16'h0);
      wr(2'd0, 4'd0, 3'b000, 8'hA1);
      chk("R10 irq on first entry", {15'h0, rx_irq}, 16'h1);
      @(negedge clk);
      chk("R10 one cycle", {15'h0, rx_irq}, 16'h0);
      wr(2'd0, 4'd0, 3'b000, 8'hA2);
      chk("R10 no irq on second", {15'h0, rx_irq}, 16'h0);
      rd(v);
      chk("R10 no irq partial drain", {15'h0, rx_irq}, 16'h0);
      irq_en = 1'b0;
      @(negedge clk);
      irq_en = 1'b1;
      #1;
      chk("R11 re-arm irq", {15'h0, rx_irq}, 16'h1);
      @(negedge clk);
      chk("R11 one cycle", {15'h0, rx_irq}, 16'h0);
      rd(v);
      chk("R5 last entry", v, {1'b1, 3'b000, 4'd0, 8'hA2});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule